// File: doc/BRIEF.md
# Programmable master video sync generator

This block is the timing master of an interlaced video path that runs on the pixel clock. A horizontal counter and a vertical counter step through a raster of `H_TOTAL` clocks by `V_TOTAL` lines. From the counter position the block builds an active-low horizontal sync, and either a field level or an active-low vertical sync pulse. The second field begins on line index `F2_LINE`, counted from 0.

A host programs the block through a small register port with synchronous writes and combinational reads. The timing register sits at address 08h. Its bits [1:0] select the horizontal sync width. Bits [3:2] select the offset from the horizontal sync leading edge to the vertical or field edge. Bits [5:4] select the vertical sync width, or the field rise offset, depending on the mode. Bits [7:6] select the shift of horizontal sync against the pixel data. The control register sits at address 07h. Its bit 0 picks the mode: 0 gives the field level and 1 gives the vertical sync pulse. Its bit 7 is the counter-restart bit.

The counters run only after bit 7 has been written high and then low. Timing and mode values are captured at that moment. Writes made later wait for the next restart, so a pulse in progress is never cut short. The programmed sum of shift, offset and width must stay below `H_TOTAL`. The same holds for shift, offset and `OFS_CLKS`.

Top module: `raster_sync_gen`

## Requirements
- R1: Horizontal sync width code [1:0] of register 08h gives a low pulse of 1, 4, 16 or 128 clocks for codes 0, 1, 2 and 3.
- R2: Shift code [7:6] places the horizontal sync leading edge at line position 0, 1, 2 or 3. The pulse then covers positions adj to adj+width-1.
- R3: Offset code [3:2] puts the vertical or field edge 0, 4, 8 or 16 clocks after the horizontal sync leading edge.
- R4: In vertical sync mode (control bit 0 = 1), vsync_no goes low on lines 0 and F2_LINE only. It starts at the R3 edge and lasts 1, 4, 16 or 128 clocks for code [5:4] = 0..3. In this mode field_o stays 0.
- R5: In field mode (control bit 0 = 0), field_o rises on line F2_LINE and falls on line 0. The fall is at the R3 edge. The rise is at the R3 edge when bit 4 is 0, and OFS_CLKS later when bit 4 is 1. Bit 5 has no effect. In this mode vsync_no stays high.
- R6: The raster position steps through H_TOTAL clocks per line and V_TOTAL lines per frame, then wraps to line 0, position 0.
- R7: After rst_ni the counters stay halted and the outputs stay inactive (hsync_no=1, vsync_no=1, field_o=0) until bit 7 has gone high and then low. Each output is registered. Position 0 of the raster appears on the outputs two clocks after the edge that captures bit 7 low.
- R8: While bit 7 is high, the counters are held at 0 and all outputs are inactive.
- R9: Writes to the timing register, and to the mode bit, change the outputs only at the next restart sequence.
- R10: Address 08h reads back the timing register. Address 07h reads back bit 7 and bit 0 of the control register, with the other bits read as 0. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low (vertical sync mode) |
| field_o | output | 1 | Field level, 1 during the second field (field mode) |

## Verification
The assertions take for granted that the shift, offset and width programmed into a line fit inside H_TOTAL. They also assume the mode changes only through a restart, which the block enforces with its capture register. The stimulus keeps to this by using a 150-clock line, longer than the largest sum of 147 clocks, and a field offset of 20 clocks. All register writes are driven half a cycle away from the capturing edge. The sweeps cover every code of each field in at least one mode over more than a full frame. One run writes new values mid-frame and checks that the old timing continues until the restart.

// File: rtl/raster_sync_pkg.sv
package raster_sync_pkg;

  typedef struct packed {
    logic [1:0] pix_adj;
    logic [1:0] vs_sel;
    logic [1:0] edge_dly;
    logic [1:0] hs_wid;
  } tmg_t;

  function automatic int unsigned pulse_len(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 16;
      default: return 128;
    endcase
  endfunction

  function automatic int unsigned edge_ofs(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_sync_pkg::*;
#(
  parameter int AW        = 5,
  parameter int TMG_ADDR  = 8,
  parameter int CTRL_ADDR = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          load_i,
  output logic          seq_bit_o,
  output tmg_t          sh_tmg_o,
  output logic          sh_vmode_o
);

  tmg_t tmg_q;
  logic vmode_q, seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmg_q   <= '0;
      vmode_q <= 1'b0;
      seq_q   <= 1'b0;
    end else if (we_i) begin
      if (addr_i == AW'(TMG_ADDR)) tmg_q <= tmg_t'(wdata_i);
      if (addr_i == AW'(CTRL_ADDR)) begin
        vmode_q <= wdata_i[0];
        seq_q   <= wdata_i[7];
      end
    end
  end

  // shadow copy used by the raster, refreshed only at restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_tmg_o   <= '0;
      sh_vmode_o <= 1'b0;
    end else if (load_i) begin
      sh_tmg_o   <= tmg_q;
      sh_vmode_o <= vmode_q;
    end
  end

  always_comb begin
    if (addr_i == AW'(TMG_ADDR))       rdata_o = tmg_q;
    else if (addr_i == AW'(CTRL_ADDR)) rdata_o = {seq_q, 6'b0, vmode_q};
    else                               rdata_o = 8'h00;
  end

  assign seq_bit_o = seq_q;

endmodule

// File: rtl/raster_cnt.sv
module raster_cnt #(
  parameter int H_TOTAL = 864,
  parameter int V_TOTAL = 625,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          seq_bit_i,
  output logic          run_o,
  output logic          load_o,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o
);

  logic armed_q, run_q;
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      h_q     <= '0;
      v_q     <= '0;
    end else if (seq_bit_i) begin
      armed_q <= 1'b1;
      run_q   <= 1'b0;
      h_q     <= '0;
      v_q     <= '0;
    end else if (armed_q) begin
      armed_q <= 1'b0;
      run_q   <= 1'b1;
      h_q     <= '0;
      v_q     <= '0;
    end else if (run_q) begin
      if (h_q == HW'(H_TOTAL - 1)) begin
        h_q <= '0;
        v_q <= (v_q == VW'(V_TOTAL - 1)) ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  assign load_o = armed_q & ~seq_bit_i;
  assign run_o  = run_q;
  assign h_o    = h_q;
  assign v_o    = v_q;

endmodule

// File: rtl/raster_shape.sv
module raster_shape
  import raster_sync_pkg::*;
#(
  parameter int H_TOTAL  = 864,
  parameter int V_TOTAL  = 625,
  parameter int F2_LINE  = 312,
  parameter int OFS_CLKS = 432,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  tmg_t          tmg_i,
  input  logic          vmode_i,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          field_o
);

  int unsigned hpos, hs_beg, hs_end, edge_pos, vs_end, rise_pos;
  logic hs_act, vs_act, on_vline, f_set, f_clr;

  always_comb begin
    hpos     = 32'(h_i);
    hs_beg   = 32'(tmg_i.pix_adj);
    hs_end   = hs_beg + pulse_len(tmg_i.hs_wid);
    edge_pos = hs_beg + edge_ofs(tmg_i.edge_dly);
    vs_end   = edge_pos + pulse_len(tmg_i.vs_sel);
    rise_pos = edge_pos + (tmg_i.vs_sel[0] ? 32'(OFS_CLKS) : 32'd0);
    on_vline = (v_i == '0) || (v_i == VW'(F2_LINE));
    hs_act   = (hpos >= hs_beg) && (hpos < hs_end);
    vs_act   = vmode_i && on_vline && (hpos >= edge_pos) && (hpos < vs_end);
    f_set    = (v_i == VW'(F2_LINE)) && (hpos == rise_pos);
    f_clr    = (v_i == '0) && (hpos == edge_pos);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_no <= 1'b1;
      vsync_no <= 1'b1;
      field_o  <= 1'b0;
    end else if (!run_i) begin
      hsync_no <= 1'b1;
      vsync_no <= 1'b1;
      field_o  <= 1'b0;
    end else begin
      hsync_no <= ~hs_act;
      vsync_no <= ~vs_act;
      if (vmode_i)    field_o <= 1'b0;
      else if (f_set) field_o <= 1'b1;
      else if (f_clr) field_o <= 1'b0;
    end
  end

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import raster_sync_pkg::*;
#(
  parameter int H_TOTAL   = 864,
  parameter int V_TOTAL   = 625,
  parameter int F2_LINE   = 312,
  parameter int OFS_CLKS  = 432,
  parameter int AW        = 5,
  parameter int TMG_ADDR  = 8,
  parameter int CTRL_ADDR = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          field_o
);

  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic          seq_bit, load, run, sh_vmode;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  tmg_t          sh_tmg;

  raster_regs #(
    .AW(AW), .TMG_ADDR(TMG_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .load_i(load),
    .seq_bit_o(seq_bit), .sh_tmg_o(sh_tmg), .sh_vmode_o(sh_vmode)
  );

  raster_cnt #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .seq_bit_i(seq_bit),
    .run_o(run), .load_o(load), .h_o(hcnt), .v_o(vcnt)
  );

  raster_shape #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .F2_LINE(F2_LINE), .OFS_CLKS(OFS_CLKS)
  ) u_shape (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .h_i(hcnt), .v_i(vcnt),
    .tmg_i(sh_tmg), .vmode_i(sh_vmode),
    .hsync_no(hsync_no), .vsync_no(vsync_no), .field_o(field_o)
  );

endmodule

// File: rtl/raster_sync_chk.sv
module raster_sync_chk #(
  parameter int H_TOTAL = 864,
  parameter int V_TOTAL = 625,
  parameter int F2_LINE = 312,
  parameter int HW      = 10,
  parameter int VW      = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic [HW-1:0] h_i,
  input logic [VW-1:0] v_i,
  input logic          hsync_no,
  input logic          vsync_no,
  input logic          field_o
);

  logic [8:0] hs_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hs_low_q <= '0;
    else if (hsync_no)    hs_low_q <= '0;
    else if (~&hs_low_q)  hs_low_q <= hs_low_q + 1'b1;
  end

  // R1: no horizontal pulse exceeds the widest code
  p_hs_max_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_low_q <= 9'd128);

  // R6: position stays inside the raster
  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(h_i) < H_TOTAL) && (32'(v_i) < V_TOTAL));

  // R6: end of line wraps to position 0
  p_line_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && 32'(h_i) == H_TOTAL - 1) |=> (h_i == '0));

  // R7: raster starts at the origin
  p_start_origin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (h_i == '0) && (v_i == '0));

  // R8: halted counters give inactive outputs
  p_hold_inactive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> hsync_no && vsync_no && !field_o);

  // R4: vertical pulse only on the two field start lines
  p_vs_lines_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_no |-> ($past(v_i) == '0) || ($past(v_i) == VW'(F2_LINE)));

  // R5: field level only moves on the two field start lines
  p_field_lines_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !$stable(field_o)) |->
      ($past(v_i) == '0) || ($past(v_i) == VW'(F2_LINE)));

  // R5: field level and vertical pulse are never both active
  p_mode_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_o || vsync_no);

endmodule

bind raster_sync_gen raster_sync_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .F2_LINE(F2_LINE), .HW(HW), .VW(VW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .h_i(hcnt), .v_i(vcnt),
  .hsync_no(hsync_no), .vsync_no(vsync_no), .field_o(field_o)
);

// File: tb/sim_raster_sync_gen.sv
`timescale 1ns/1ps
module sim_raster_sync_gen;

  localparam int H = 150;
  localparam int V = 6;
  localparam int F2 = 3;
  localparam int OFS = 20;
  localparam int FRAME = H * V;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       hs_n, vs_n, fld;

  always #2.5 clk = ~clk;

  raster_sync_gen #(
    .H_TOTAL(H), .V_TOTAL(V), .F2_LINE(F2), .OFS_CLKS(OFS),
    .AW(5), .TMG_ADDR(8), .CTRL_ADDR(7)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .hsync_no(hs_n), .vsync_no(vs_n), .field_o(fld)
  );

  int vec = 0, bad = 0, p = 0;
  logic [7:0] live_tm = '0, sh_tm = '0;
  logic sh_mode = 1'b0, mfld = 1'b0;
  bit done = 0;

  function automatic int wlen(input logic [1:0] c);
    return (c == 2'd3) ? 128 : (1 << (2 * c));
  endfunction
  function automatic int wofs(input logic [1:0] c);
    return (c == 2'd3) ? 16 : 4 * c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s p=%0d act=%0d exp=%0d", req, p, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
    if (a == 5'd8) live_tm = d;
  endtask

  task automatic start_model(input logic m);
    @(posedge clk);
    p = 0; mfld = 1'b0; sh_tm = live_tm; sh_mode = m;
  endtask

  task automatic restart(input logic m);
    wr(5'd7, {1'b1, 6'b0, m});
    wr(5'd7, {1'b0, 6'b0, m});
    start_model(m);
  endtask

  task automatic step();
    int h, v, adj, edg, rise;
    bit ehs, evs;
    @(posedge clk);
    @(negedge clk);
    h = p % H;
    v = (p / H) % V;
    adj = int'(sh_tm[7:6]);
    edg = adj + wofs(sh_tm[3:2]);
    rise = edg + (sh_tm[4] ? OFS : 0);
    ehs = !(h >= adj && h < adj + wlen(sh_tm[1:0]));
    evs = !(sh_mode && (v == 0 || v == F2) && h >= edg && h < edg + wlen(sh_tm[5:4]));
    if (sh_mode) mfld = 1'b0;
    else if (v == F2 && h == rise) mfld = 1'b1;
    else if (v == 0 && h == edg) mfld = 1'b0;
    chk(hs_n == ehs, "R1 R2 R6 hsync_no", int'(hs_n), int'(ehs));
    chk(vs_n == evs, "R3 R4 vsync_no", int'(vs_n), int'(evs));
    chk(fld == mfld, "R3 R5 field_o", int'(fld), int'(mfld));
    p++;
  endtask

  // run n samples; optional write driven after sample wr_at
  task automatic run_n(input int n, input int wr_at, input logic [4:0] a, input logic [7:0] d);
    for (int i = 0; i < n; i++) begin
      step();
      if (i == wr_at) begin
        we = 1'b1; addr = a; wdata = d;
        if (a == 5'd8) live_tm = d;
      end else if (i == wr_at + 1) begin
        we = 1'b0;
      end
    end
  endtask

  task automatic idle_chk(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(hs_n && vs_n && !fld, req, int'({hs_n, vs_n, fld}), 6);
    end
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(rdata == exp, "R10 readback", int'(rdata), int'(exp));
  endtask

  initial begin
    #12 rst_n = 1'b1;
    idle_chk(20, "R7 reset state");
    wr(5'd8, 8'hA5);
    wr(5'd7, 8'h01);
    idle_chk(200, "R7 halted without sequence");
    rd_chk(5'd8, 8'hA5);
    rd_chk(5'd7, 8'h01);
    rd_chk(5'd3, 8'h00);
    wr(5'd7, 8'hFF);
    rd_chk(5'd7, 8'h81);

    // sweep: width x shift, vertical sync mode
    for (int a = 0; a < 4; a++)
      for (int w = 0; w < 4; w++) begin
        wr(5'd8, {2'(a), 2'b00, 2'b00, 2'(w)});
        restart(1'b1);
        run_n(FRAME + H, -5, 5'd0, 8'h00);
      end

    // R8: hold while restart bit high, then finish the sequence
    wr(5'd7, 8'h81);
    repeat (3) @(posedge clk);
    idle_chk(60, "R8 hold while bit high");
    wr(5'd7, 8'h01);
    start_model(1'b1);
    run_n(H, -5, 5'd0, 8'h00);

    // sweep: offset x vertical width, vertical sync mode
    for (int dl = 0; dl < 4; dl++)
      for (int w = 0; w < 4; w++) begin
        wr(5'd8, {2'd2, 2'(w), 2'(dl), 2'd1});
        restart(1'b1);
        run_n(FRAME + H, -5, 5'd0, 8'h00);
      end

    // sweep: offset x field code, field mode
    for (int dl = 0; dl < 4; dl++)
      for (int f = 0; f < 4; f++) begin
        wr(5'd8, {2'd1, 2'(f), 2'(dl), 2'd0});
        restart(1'b0);
        run_n(FRAME + H, -5, 5'd0, 8'h00);
      end

    // R9: mid-frame writes wait for the next restart
    wr(5'd8, 8'b10_01_10_01);
    restart(1'b1);
    run_n(300, 100, 5'd8, 8'b01_01_01_11);
    run_n(FRAME + 50, 10, 5'd7, 8'h00);
    rd_chk(5'd8, 8'b01_01_01_11);
    rd_chk(5'd7, 8'h00);
    restart(1'b0);
    run_n(FRAME + H, -5, 5'd0, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(160000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule